// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small microcontroller core and handles interrupt entry and return. A divide-by-N prescaler turns the input clock into CPU-cycle ticks. At each tick where the core reports a finished instruction, the sequencer does one of three things. It takes a non-maskable or maskable interrupt. It returns from one. Or it does nothing. Requests that arrive in the middle of an instruction wait for the next instruction boundary.

Taking an interrupt does four things. The current program counter and the current flag-bank mode go onto an internal hardware stack. The vector of the accepted source is loaded into the program counter. The active carry/zero flag bank switches to the interrupt bank or to the non-maskable bank. Maskable interrupts are turned off while the core is out of normal mode. A return pops the stack and restores both the program counter and the mode it saved. Maskable interrupts come back on only when that restored mode is normal. A fixed entry latency, counted in CPU cycles, ends with a ready pulse. While that latency runs, instruction boundaries are ignored.

Top module: `irq_seq`

## Requirements
- R1: `cpu_tick` is high for one clock in every CLK_DIV clocks. State changes only at a clock edge where `cpu_tick` and `instr_done` are both high. All output pulses last exactly one clock.
- R2: A non-maskable request at a boundary, outside non-maskable mode, is taken. It loads `pc_next` with NMI_VEC, pulses `pc_load` and sets `bank_sel` to 2. A non-maskable request wins over a maskable request at the same boundary.
- R3: A maskable request is taken only when `irq_req`, `irq_mask` and `gie` are all high. Taking it sets `bank_sel` to 1 (0 = normal, 1 = interrupt, 2 = non-maskable), loads IRQ_VEC, drops `gie` and pulses `src_clr`. A masked request has no effect.
- R4: Each entry pushes the interrupted `pc_cur` and the current mode onto the stack and pulses `stk_push`.
- R5: A RETI boundary outside normal mode pops the stack and pulses `stk_pop` and `pc_load`. It puts the saved PC on `pc_next` and restores the saved mode. `gie` returns high only when the restored mode is normal.
- R6: A RETI boundary in normal mode pulses `reti_err`. It changes neither the stack, the PC output nor the mode.
- R7: A request taken while the stack is full is not taken. `stk_ovf` goes high and stays high until reset. Nothing is pushed and the mode is unchanged.
- R8: `vec_ready` pulses at the ENTRY_TICKS-th tick after the entry tick. Boundaries arriving before that pulse, or at the same tick, are ignored.
- R9: After reset, `bank_sel` is 0, `gie` is 1, `pc_next` is 0, `stk_ovf` is 0 and every pulse is low.
- R10: At a RETI boundary, the return is handled and no request is taken at that boundary. A non-maskable request in non-maskable mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| instr_done | input | 1 | Core finished an instruction (sampled on ticks) |
| reti_done | input | 1 | The finished instruction was a return-from-interrupt |
| irq_req | input | 1 | Maskable request line |
| irq_mask | input | 1 | Mask bit for the maskable line (1 = allowed) |
| nmi_req | input | 1 | Non-maskable request line |
| pc_cur | input | PC_W | Program counter of the next instruction |
| cpu_tick | output | 1 | One-clock CPU-cycle enable |
| pc_next | output | PC_W | Vector or restored program counter |
| pc_load | output | 1 | Pulse: core loads `pc_next` |
| stk_push | output | 1 | Pulse: entry pushed the stack |
| stk_pop | output | 1 | Pulse: return popped the stack |
| bank_sel | output | 2 | Active flag bank: 0 normal, 1 interrupt, 2 non-maskable |
| gie | output | 1 | Global maskable-interrupt enable |
| src_clr | output | 1 | Pulse clearing the maskable source latch |
| vec_ready | output | 1 | Pulse: entry latency elapsed, handler may run |
| stk_ovf | output | 1 | Sticky stack-overflow flag |
| reti_err | output | 1 | Pulse: RETI seen in normal mode |

## Verification
The bench builds the main instance with CLK_DIV=4, so a long random run fits in few clocks. It uses a two-deep stack, which is exactly the nesting the modes allow (normal, then interrupt, then non-maskable), so returns into interrupt mode are reachable. ENTRY_TICKS is set to 7 so the ignore window is not the minimum. A second instance, built with a one-deep stack and fed the same inputs, makes the overflow hold-off reachable when a non-maskable request arrives during a maskable handler.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [1:0] {
      MODE_NORM = 2'd0,
      MODE_IRQ  = 2'd1,
      MODE_NMI  = 2'd2
   } mode_e;
endpackage

// File: rtl/irq_seq_tick.sv
module irq_seq_tick #(
   parameter int DIV = 13
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("irq_seq_tick: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (cnt_q == CW'(DIV-1))  cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == CW'(DIV-1));

   // R1: a tick never lasts two clocks
   p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
   parameter int DEPTH = 6,
   parameter int W     = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("irq_seq_stack: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] cnt_q;

   assign full  = (cnt_q == PW'(DEPTH));
   assign empty = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (push && !full)  cnt_q <= cnt_q + 1'b1;
      else if (pop && !empty)  cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && !full && cnt_q == PW'(i)) mem_q[i] <= din;
      end
   end

   always_comb begin
      dout = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == PW'(i + 1)) dout = mem_q[i];
      end
   end

   // R7: the controller never pushes a full stack
   p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R5: the controller never pops an empty stack
   p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int          PC_W        = 12,
   parameter int          STK_DEPTH   = 6,
   parameter int          CLK_DIV     = 13,
   parameter int          ENTRY_TICKS = 6,
   parameter int unsigned NMI_VEC     = 32'hFFC,
   parameter int unsigned IRQ_VEC     = 32'hFF8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_done,
   input  logic            reti_done,
   input  logic            irq_req,
   input  logic            irq_mask,
   input  logic            nmi_req,
   input  logic [PC_W-1:0] pc_cur,
   output logic            cpu_tick,
   output logic [PC_W-1:0] pc_next,
   output logic            pc_load,
   output logic            stk_push,
   output logic            stk_pop,
   output logic [1:0]      bank_sel,
   output logic            gie,
   output logic            src_clr,
   output logic            vec_ready,
   output logic            stk_ovf,
   output logic            reti_err
);
   localparam int EW = PC_W + 2;
   localparam int CW = $clog2(ENTRY_TICKS + 1);
   localparam logic [PC_W-1:0] NMI_PC = PC_W'(NMI_VEC);
   localparam logic [PC_W-1:0] IRQ_PC = PC_W'(IRQ_VEC);

   generate
      if (ENTRY_TICKS < 6 || ENTRY_TICKS > 11) begin : g_bad_entry
         $error("irq_seq: ENTRY_TICKS must lie in 6..11");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("irq_seq: PC_W too small");
      end
   endgenerate

   mode_e         mode_q;
   logic [CW-1:0] ent_q;
   logic          tick;
   logic          full, empty;
   logic [EW-1:0] top;
   logic          busy, bound, do_ret, ret_bad, want_nmi, want_irq, take;

   irq_seq_tick #(.DIV(CLK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   assign cpu_tick = tick;
   assign gie      = (mode_q == MODE_NORM);
   assign bank_sel = mode_q;

   assign busy     = (ent_q != '0);
   assign bound    = tick && instr_done && !busy;
   assign do_ret   = bound && reti_done && (mode_q != MODE_NORM) && !empty;
   assign ret_bad  = bound && reti_done && (mode_q == MODE_NORM);
   assign want_nmi = bound && !reti_done && nmi_req && (mode_q != MODE_NMI);
   assign want_irq = bound && !reti_done && !want_nmi && irq_req && irq_mask && gie;
   assign take     = (want_nmi || want_irq) && !full;

   irq_seq_stack #(.DEPTH(STK_DEPTH), .W(EW)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (take),
      .pop   (do_ret),
      .din   ({mode_q, pc_cur}),
      .dout  (top),
      .full  (full),
      .empty (empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_NORM;
         ent_q     <= '0;
         pc_next   <= '0;
         pc_load   <= 1'b0;
         stk_push  <= 1'b0;
         stk_pop   <= 1'b0;
         src_clr   <= 1'b0;
         vec_ready <= 1'b0;
         reti_err  <= 1'b0;
         stk_ovf   <= 1'b0;
      end else begin
         pc_load   <= 1'b0;
         stk_push  <= 1'b0;
         stk_pop   <= 1'b0;
         src_clr   <= 1'b0;
         vec_ready <= 1'b0;
         reti_err  <= 1'b0;
         if (tick && busy) begin
            ent_q <= ent_q - 1'b1;
            if (ent_q == CW'(1)) vec_ready <= 1'b1;
         end
         if (take) begin
            mode_q   <= want_nmi ? MODE_NMI : MODE_IRQ;
            pc_next  <= want_nmi ? NMI_PC : IRQ_PC;
            pc_load  <= 1'b1;
            stk_push <= 1'b1;
            src_clr  <= want_irq;
            ent_q    <= CW'(ENTRY_TICKS);
         end
         if ((want_nmi || want_irq) && full) stk_ovf <= 1'b1;
         if (do_ret) begin
            mode_q  <= mode_e'(top[EW-1:PC_W]);
            pc_next <= top[PC_W-1:0];
            pc_load <= 1'b1;
            stk_pop <= 1'b1;
         end
         if (ret_bad) reti_err <= 1'b1;
      end
   end

   // R4/R5/R6: one stack or error event per boundary
   p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_push, stk_pop, reti_err}));
   // R1: PC loads follow a tick edge only
   p_load_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> $past(cpu_tick));
   // R3: entry leaves maskable interrupts off
   p_entry_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |-> !gie);
   // R3: latch clear only on a maskable entry
   p_clr_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      src_clr |-> (bank_sel == 2'd1));
   // R6: bad return leaves normal bank in place
   p_reti_err_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reti_err |-> (bank_sel == 2'd0));
   // R7: overflow flag is sticky
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf |=> stk_ovf);
endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
   localparam int PC_W = 12;
   localparam int DIV  = 4;
   localparam int ENT  = 7;
   localparam logic [11:0] NMI_V = 12'hABC;
   localparam logic [11:0] IRQ_V = 12'h123;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic instr_done = 0, reti_done = 0, irq_req = 0, irq_mask = 0, nmi_req = 0;
   logic [11:0] pc_cur = '0;

   logic        t0_tick, t0_load, t0_push, t0_pop, t0_gie, t0_clr, t0_vr, t0_ovf, t0_err;
   logic [11:0] t0_pc;
   logic [1:0]  t0_bank;
   logic        t1_tick, t1_load, t1_push, t1_pop, t1_gie, t1_clr, t1_vr, t1_ovf, t1_err;
   logic [11:0] t1_pc;
   logic [1:0]  t1_bank;

   always #4 clk = ~clk;

   irq_seq #(.PC_W(PC_W), .STK_DEPTH(2), .CLK_DIV(DIV), .ENTRY_TICKS(ENT),
             .NMI_VEC(32'hABC), .IRQ_VEC(32'h123)) u0 (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .reti_done(reti_done),
      .irq_req(irq_req), .irq_mask(irq_mask), .nmi_req(nmi_req), .pc_cur(pc_cur),
      .cpu_tick(t0_tick), .pc_next(t0_pc), .pc_load(t0_load), .stk_push(t0_push),
      .stk_pop(t0_pop), .bank_sel(t0_bank), .gie(t0_gie), .src_clr(t0_clr),
      .vec_ready(t0_vr), .stk_ovf(t0_ovf), .reti_err(t0_err));

   irq_seq #(.PC_W(PC_W), .STK_DEPTH(1), .CLK_DIV(DIV), .ENTRY_TICKS(ENT),
             .NMI_VEC(32'hABC), .IRQ_VEC(32'h123)) u1 (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .reti_done(reti_done),
      .irq_req(irq_req), .irq_mask(irq_mask), .nmi_req(nmi_req), .pc_cur(pc_cur),
      .cpu_tick(t1_tick), .pc_next(t1_pc), .pc_load(t1_load), .stk_push(t1_push),
      .stk_pop(t1_pop), .bank_sel(t1_bank), .gie(t1_gie), .src_clr(t1_clr),
      .vec_ready(t1_vr), .stk_ovf(t1_ovf), .reti_err(t1_err));

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 0;

   // reference model state
   int          m_mode = 0;
   int          m_sp = 0;
   int          m_ent = 0;
   bit          m_ovf = 0;
   logic [11:0] m_spc [2];
   int          m_smode [2];

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [11:0] entry_vec(bit is_nmi);
      return is_nmi ? NMI_V : IRQ_V;
   endfunction

   task automatic step(bit d, bit r, bit iq, bit im, bit n, logic [11:0] pc);
      bit e_load = 0, e_push = 0, e_pop = 0, e_clr = 0, e_vr = 0, e_err = 0;
      logic [11:0] e_pc = '0;
      do @(negedge clk); while (!t0_tick);
      instr_done = d; reti_done = r; irq_req = iq; irq_mask = im; nmi_req = n; pc_cur = pc;
      if (m_ent != 0) begin
         if (m_ent == 1) e_vr = 1;
         m_ent--;
      end else if (d) begin
         if (r) begin
            if (m_mode == 0) e_err = 1;
            else begin
               m_sp--; e_pc = m_spc[m_sp]; m_mode = m_smode[m_sp];
               e_load = 1; e_pop = 1;
            end
         end else if ((n && m_mode != 2) || (iq && im && m_mode == 0)) begin
            bit isn = n && (m_mode != 2);
            if (m_sp == 2) m_ovf = 1;
            else begin
               m_spc[m_sp] = pc; m_smode[m_sp] = m_mode; m_sp++;
               m_mode = isn ? 2 : 1; e_pc = entry_vec(isn);
               e_load = 1; e_push = 1; e_clr = !isn; m_ent = ENT;
            end
         end
      end
      @(negedge clk);
      check("R2 pc_load", t0_load, e_load);
      if (e_load) check("R5 pc_next", t0_pc, e_pc);
      check("R4 stk_push", t0_push, e_push);
      check("R5 stk_pop", t0_pop, e_pop);
      check("R3 src_clr", t0_clr, e_clr);
      check("R8 vec_ready", t0_vr, e_vr);
      check("R6 reti_err", t0_err, e_err);
      check("R10 bank_sel", t0_bank, m_mode);
      check("R5 gie", t0_gie, m_mode == 0);
      check("R7 stk_ovf", t0_ovf, m_ovf);
      instr_done = 0; reti_done = 0; irq_req = 0; irq_mask = 0; nmi_req = 0;
      @(negedge clk);
      check("R1 pulse width", {t0_load, t0_push, t0_pop, t0_clr, t0_vr, t0_err}, 0);
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 12'h000);
   endtask

   initial begin
      #(8 * 200000);
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      if (!done_flag) begin
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int gap;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check("R9 bank", t0_bank, 0);
      check("R9 gie", t0_gie, 1);
      check("R9 pc_next", t0_pc, 0);
      check("R9 ovf", t0_ovf, 0);
      check("R9 pulses", {t0_load, t0_push, t0_pop, t0_clr, t0_vr, t0_err}, 0);
      // R1: tick period
      while (!t0_tick) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!t0_tick);
      check("R1 tick period", gap, DIV);
      // R1: requests without a boundary are ignored
      step(0, 0, 1, 1, 1, 12'h111);
      // R3: masked request ignored
      step(1, 0, 1, 0, 0, 12'h222);
      // R6: RETI in normal mode
      step(1, 1, 0, 0, 0, 12'h233);
      // R3: maskable entry (both instances)
      step(1, 0, 1, 1, 0, 12'h345);
      check("R3 u1 bank", t1_bank, 1);
      // R8: boundaries during the entry window are ignored
      step(1, 0, 0, 0, 1, 12'h346);
      idle(ENT - 2);
      step(1, 0, 0, 0, 1, 12'h347); // last busy tick: ignored, vec_ready due
      // R2: NMI nests over IRQ on u0; R7: u1 stack full
      step(1, 0, 1, 1, 1, 12'h456);
      check("R7 u1 ovf", t1_ovf, 1);
      check("R7 u1 bank", t1_bank, 1);
      check("R7 u1 push", t1_push, 0);
      idle(ENT);
      // R10: NMI in NMI mode ignored
      step(1, 0, 0, 0, 1, 12'h567);
      // R5: return into IRQ mode, gie stays low
      step(1, 1, 0, 0, 0, 12'h568);
      // R5: return to normal, gie back
      step(1, 1, 0, 0, 0, 12'h569);
      // R2: NMI wins over IRQ
      step(1, 0, 1, 1, 1, 12'h600);
      idle(ENT);
      step(1, 1, 0, 0, 0, 12'h601);
      // R10: RETI with NMI at same boundary: return only
      step(1, 0, 1, 1, 0, 12'h700);
      idle(ENT);
      step(1, 1, 0, 0, 1, 12'h701);
      step(1, 0, 0, 0, 1, 12'h702);
      idle(ENT);
      step(1, 1, 0, 0, 0, 12'h703);
      // random phase
      for (int i = 0; i < 1500; i++) begin
         bit d  = ($urandom % 3) == 0;
         bit r  = d && (($urandom % 3) == 0);
         bit iq = $urandom % 2;
         bit im = ($urandom % 4) != 0;
         bit n  = ($urandom % 8) == 0;
         step(d, r, iq, im, n, 12'($urandom));
      end
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule